// File: doc/BRIEF.md
# MSI and INTx Interrupt Aggregator

This block gathers 32 message-signalled interrupt vectors and 4 level-sensitive INTx lines and presents them as 8 MSI interrupt outputs and 4 INTx interrupt outputs. A vector is raised by writing its number to a doorbell register. The write can arrive over the 32-bit register bus or over a dedicated inbound port that the PCIe receive path drives. The vectors are interleaved across the 8 MSI groups. Vector v lands in group v mod 8 at bit v div 8, so group 0 holds vectors 0, 8, 16 and 24 in bits 0 to 3.

Each group has a status register and a pair of enable aliases, spaced 0x10 apart. Status bits are cleared by writing 1 to them. One enable alias sets mask bits and the other clears them. Each INTx line has its own status and enable registers. Software ends an interrupt by writing a code to the EOI register. The code is 4 + g for MSI group g, or i for INTx line i. The targeted output then drops for a cycle and rises again if enabled work is still pending. Reads are combinational from the register address.

Top module: `irq_agg_top`

## Requirements
- R1: A doorbell write (bus write to 0x054, or `ib_we` with `ib_vector`) of vector v sets status bit v div 8 of MSI group v mod 8 on the next clock edge. Only the low 5 bits of the bus write data are used. The status of group g reads at 0x104 + 0x10*g, in bits 3:0.
- R2: A doorbell for a vector that is already pending leaves all status bits unchanged.
- R3: A write to a group status register clears exactly the bits written as 1 and leaves the other bits unchanged.
- R4: When a doorbell and a status clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to 0x108 + 0x10*g sets the enable bits of group g that are written as 1. A write to 0x10C + 0x10*g clears the enable bits written as 1. Reading either address returns the group's enable mask in bits 3:0.
- R6: `msi_irq[g]` is high one cycle after a cycle in which group g has a bit that is both pending and enabled.
- R7: A write of 4 + g to 0x050 forces `msi_irq[g]` low in the following cycle. The output rises again in the cycle after that if an enabled bit is still pending.
- R8: The INTx status of line i (0x184 + 0x10*i, bit 0) follows `intx_level[i]` with one cycle of delay. The enable bit is set by writing bit 0 = 1 to 0x188 + 0x10*i and cleared by writing bit 0 = 1 to 0x18C + 0x10*i, and both addresses read it back. `intx_irq[i]` is high one cycle after status and enable are both 1.
- R9: A write of i (0 to 3) to 0x050 forces `intx_irq[i]` low in the following cycle.
- R10: After reset, all status, enable and output bits are 0. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address (read and write) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| ib_we | input | 1 | Inbound doorbell strobe |
| ib_vector | input | 5 | Inbound doorbell vector number |
| intx_level | input | 4 | INTx level inputs |
| msi_irq | output | 8 | Per-group MSI interrupt outputs |
| intx_irq | output | 4 | Per-line INTx interrupt outputs |

## Verification
The bench drives doorbell writes with junk in the upper data bits. A decoder that used all of the data would then set the wrong bit or none at all. It also sends an inbound doorbell together with a status clear of the same bit. A design in which the clear wins would lose that interrupt. EOI writes land while work is still pending and enabled. A design with no drop would keep the output flat, and one that stayed low would lose the re-assertion. Clears with mixed masks, and repeated doorbells, show whether neighbouring bits survive.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int          ADDR_W        = 12;
    localparam int          DATA_W        = 32;
    localparam logic [11:0] EOI_ADDR      = 12'h050;
    localparam logic [11:0] DOORBELL_ADDR = 12'h054;
    localparam logic [7:0]  MSI_ROW_BASE  = 8'h10;
    localparam logic [7:0]  INTX_ROW_BASE = 8'h18;
    localparam logic [3:0]  SLOT_STATUS   = 4'h4;
    localparam logic [3:0]  SLOT_EN_SET   = 4'h8;
    localparam logic [3:0]  SLOT_EN_CLR   = 4'hC;
    localparam int          EOI_MSI_BASE  = 4;
endpackage

// File: rtl/irq_agg_msi_group.sv
module irq_agg_msi_group #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             w1c_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             eoi_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] en_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [WIDTH-1:0] pend;
        logic [WIDTH-1:0] en;
        logic             irq;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set is applied after the clear so that a set in the same cycle wins
        st_d.pend = (st_q.pend & ~(w1c_i ? wdata_i : '0)) | set_i;
        st_d.en   = (st_q.en | (en_set_i ? wdata_i : '0)) & ~(en_clr_i ? wdata_i : '0);
        st_d.irq  = (|(st_q.pend & st_q.en)) && !eoi_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
    // R3
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i && set_i == '0) |=>
        ((pend_o & ~$past(wdata_i)) == ($past(pend_o) & ~$past(wdata_i))));
    // R7
    msi_eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !irq_o);
    // R6
    msi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(pend_o & en_o)));
endmodule

// File: rtl/irq_agg_intx_line.sv
module irq_agg_intx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic en_set_i,
    input  logic en_clr_i,
    input  logic eoi_i,
    output logic stat_o,
    output logic en_o,
    output logic irq_o
);
    typedef struct packed {
        logic stat;
        logic en;
        logic irq;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = level_i;
        if (en_set_i) st_d.en = 1'b1;
        if (en_clr_i) st_d.en = 1'b0;
        st_d.irq  = st_q.stat && st_q.en && !eoi_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;

    // R9
    intx_eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !irq_o);
    // R8
    intx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(stat_o && en_o));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_BITS = 4,
    parameter int NUM_INTX   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  ib_we,
    input  logic [4:0]            ib_vector,
    input  logic [NUM_INTX-1:0]   intx_level,
    output logic [NUM_GROUPS-1:0] msi_irq,
    output logic [NUM_INTX-1:0]   intx_irq
);
    localparam int NUM_VEC = NUM_GROUPS * GROUP_BITS;
    localparam int VEC_W   = $clog2(NUM_VEC);

    logic [NUM_GROUPS-1:0][GROUP_BITS-1:0] msi_set, msi_pend, msi_en;
    logic [NUM_GROUPS-1:0] msi_w1c, msi_en_set, msi_en_clr, msi_eoi;
    logic [NUM_INTX-1:0]   intx_stat, intx_en, intx_en_set, intx_en_clr, intx_eoi;
    logic [7:0]            row;
    logic [3:0]            slot;
    logic                  db_bus, eoi_wr;

    assign row    = bus_addr[11:4];
    assign slot   = bus_addr[3:0];
    assign db_bus = bus_we && (bus_addr == DOORBELL_ADDR);
    assign eoi_wr = bus_we && (bus_addr == EOI_ADDR);

    always_comb begin
        msi_set = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if ((db_bus && bus_wdata[VEC_W-1:0] == VEC_W'(v)) ||
                (ib_we && ib_vector == VEC_W'(v)))
                msi_set[v % NUM_GROUPS][v / NUM_GROUPS] = 1'b1;
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            msi_w1c[g]    = bus_we && row == 8'(MSI_ROW_BASE + g) && slot == SLOT_STATUS;
            msi_en_set[g] = bus_we && row == 8'(MSI_ROW_BASE + g) && slot == SLOT_EN_SET;
            msi_en_clr[g] = bus_we && row == 8'(MSI_ROW_BASE + g) && slot == SLOT_EN_CLR;
            msi_eoi[g]    = eoi_wr && bus_wdata == 32'(EOI_MSI_BASE + g);
        end
        for (int i = 0; i < NUM_INTX; i++) begin
            intx_en_set[i] = bus_we && row == 8'(INTX_ROW_BASE + i) &&
                             slot == SLOT_EN_SET && bus_wdata[0];
            intx_en_clr[i] = bus_we && row == 8'(INTX_ROW_BASE + i) &&
                             slot == SLOT_EN_CLR && bus_wdata[0];
            intx_eoi[i]    = eoi_wr && bus_wdata == 32'(i);
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (row == 8'(MSI_ROW_BASE + g)) begin
                if (slot == SLOT_STATUS) bus_rdata = DATA_W'(msi_pend[g]);
                if (slot == SLOT_EN_SET || slot == SLOT_EN_CLR)
                    bus_rdata = DATA_W'(msi_en[g]);
            end
        end
        for (int i = 0; i < NUM_INTX; i++) begin
            if (row == 8'(INTX_ROW_BASE + i)) begin
                if (slot == SLOT_STATUS) bus_rdata = DATA_W'(intx_stat[i]);
                if (slot == SLOT_EN_SET || slot == SLOT_EN_CLR)
                    bus_rdata = DATA_W'(intx_en[i]);
            end
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_msi
        irq_agg_msi_group #(.WIDTH(GROUP_BITS)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (msi_set[g]),
            .w1c_i    (msi_w1c[g]),
            .en_set_i (msi_en_set[g]),
            .en_clr_i (msi_en_clr[g]),
            .wdata_i  (bus_wdata[GROUP_BITS-1:0]),
            .eoi_i    (msi_eoi[g]),
            .pend_o   (msi_pend[g]),
            .en_o     (msi_en[g]),
            .irq_o    (msi_irq[g])
        );
    end

    for (genvar i = 0; i < NUM_INTX; i++) begin : g_intx
        irq_agg_intx_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_i  (intx_level[i]),
            .en_set_i (intx_en_set[i]),
            .en_clr_i (intx_en_clr[i]),
            .eoi_i    (intx_eoi[i]),
            .stat_o   (intx_stat[i]),
            .en_o     (intx_en[i]),
            .irq_o    (intx_irq[i])
        );
    end

    // R1
    doorbell_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_we |=> msi_pend[$past(ib_vector) % NUM_GROUPS][$past(ib_vector) / NUM_GROUPS]);
endmodule

// File: tb/irq_agg_top_test.sv
module irq_agg_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ib_we = 1'b0;
    logic [4:0]  ib_vector = '0;
    logic [3:0]  intx_level = '0;
    logic [7:0]  msi_irq;
    logic [3:0]  intx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    bit [3:0] mp [8];
    bit [3:0] me [8];
    bit       ist [4];
    bit       ie [4];

    always #4 clk = ~clk;

    irq_agg_top uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ib_we(ib_we),
        .ib_vector(ib_vector), .intx_level(intx_level), .msi_irq(msi_irq),
        .intx_irq(intx_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [7:0] row = a[11:4];
        logic [3:0] slot = a[3:0];
        if (row >= 8'h10 && row <= 8'h17) begin
            if (slot == 4'h4) return 32'(mp[row - 8'h10]);
            if (slot == 4'h8 || slot == 4'hC) return 32'(me[row - 8'h10]);
        end
        if (row >= 8'h18 && row <= 8'h1B) begin
            if (slot == 4'h4) return 32'(ist[row - 8'h18]);
            if (slot == 4'h8 || slot == 4'hC) return 32'(ie[row - 8'h18]);
        end
        return 32'h0;
    endfunction

    task automatic rd_chk(input logic [11:0] a, input string tag);
        logic [31:0] e;
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        e = exp_rd(a);
        check(bus_rdata === e, tag, bus_rdata, e);
    endtask

    // One bus/inbound operation across one clock edge, with model update and output checks
    task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d,
                       input bit ibw, input logic [4:0] ibv, input string tag);
        logic [7:0] emi;
        logic [3:0] eii;
        for (int g = 0; g < 8; g++)
            emi[g] = (|(mp[g] & me[g])) && !(we && a == 12'h050 && d == 32'(4 + g));
        for (int i = 0; i < 4; i++)
            eii[i] = ist[i] && ie[i] && !(we && a == 12'h050 && d == 32'(i));
        bus_we = we; bus_addr = a; bus_wdata = d; ib_we = ibw; ib_vector = ibv;
        @(posedge clk);
        for (int g = 0; g < 8; g++) begin
            if (we && a == 12'h104 + 12'(16 * g)) mp[g] = mp[g] & ~d[3:0];
            if (we && a == 12'h108 + 12'(16 * g)) me[g] = me[g] | d[3:0];
            if (we && a == 12'h10C + 12'(16 * g)) me[g] = me[g] & ~d[3:0];
        end
        if (we && a == 12'h054) mp[d[4:0] % 8][d[4:0] / 8] = 1'b1;
        if (ibw) mp[ibv % 8][ibv / 8] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ist[i] = intx_level[i];
            if (we && a == 12'h188 + 12'(16 * i) && d[0]) ie[i] = 1'b1;
            if (we && a == 12'h18C + 12'(16 * i) && d[0]) ie[i] = 1'b0;
        end
        #1;
        bus_we = 1'b0; ib_we = 1'b0;
        check(msi_irq === emi, {tag, " R6 msi_irq"}, 32'(msi_irq), 32'(emi));
        check(intx_irq === eii, {tag, " R8 intx_irq"}, 32'(intx_irq), 32'(eii));
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 12'h000, 32'h0, 1'b0, 5'd0, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int g = 0; g < 8; g++) begin mp[g] = '0; me[g] = '0; end
        for (int i = 0; i < 4; i++) begin ist[i] = 1'b0; ie[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R10 reset state
        check(msi_irq === 8'h0, "R10 msi_irq reset", 32'(msi_irq), 32'h0);
        check(intx_irq === 4'h0, "R10 intx_irq reset", 32'(intx_irq), 32'h0);
        for (int g = 0; g < 8; g++) begin
            rd_chk(12'h104 + 12'(16 * g), "R10 status reset");
            rd_chk(12'h108 + 12'(16 * g), "R10 enable reset");
        end
        rd_chk(12'h300, "R10 unmapped read");
        rd_chk(12'h050, "R10 eoi read");

        // R1 doorbell with junk upper bits: vector 13 -> group 5 bit 1
        cyc(1'b1, 12'h054, 32'hFFFF_FFE0 | 32'd13, 1'b0, 5'd0, "R1");
        rd_chk(12'h154, "R1 status group5");
        check(bus_rdata === 32'h2, "R1 vector13 bit", bus_rdata, 32'h2);
        // R1 inbound doorbell, vector 31 -> group 7 bit 3
        cyc(1'b0, 12'h000, 32'h0, 1'b1, 5'd31, "R1");
        rd_chk(12'h174, "R1 status group7");

        // R2 repeat doorbell on pending vector 9
        cyc(1'b0, 12'h000, 32'h0, 1'b1, 5'd9, "R2");
        cyc(1'b1, 12'h054, 32'd9, 1'b0, 5'd0, "R2");
        rd_chk(12'h114, "R2 repeat doorbell");
        cyc(1'b1, 12'h114, 32'h2, 1'b0, 5'd0, "R2");
        rd_chk(12'h114, "R2 single clear empties");

        // R3 partial clear: group 1 bits 0,2 pending, clear bit 0 only
        cyc(1'b0, 12'h000, 32'h0, 1'b1, 5'd1, "R3");
        cyc(1'b0, 12'h000, 32'h0, 1'b1, 5'd17, "R3");
        cyc(1'b1, 12'h114, 32'h1, 1'b0, 5'd0, "R3");
        rd_chk(12'h114, "R3 partial clear");

        // R4 set and clear of vector 17 in the same cycle
        cyc(1'b1, 12'h114, 32'h4, 1'b1, 5'd17, "R4");
        rd_chk(12'h114, "R4 set wins");
        check(bus_rdata === 32'h4, "R4 bit2 kept", bus_rdata, 32'h4);

        // R5 enables and R6/R7 EOI drop and re-assert on group 1
        cyc(1'b1, 12'h118, 32'hF, 1'b0, 5'd0, "R5");
        rd_chk(12'h118, "R5 enable set alias");
        cyc(1'b1, 12'h11C, 32'h3, 1'b0, 5'd0, "R5");
        rd_chk(12'h11C, "R5 enable clear alias");
        idle("R6");
        check(msi_irq[1] === 1'b1, "R6 group1 asserted", 32'(msi_irq), 32'h2);
        cyc(1'b1, 12'h050, 32'd5, 1'b0, 5'd0, "R7");
        check(msi_irq[1] === 1'b0, "R7 group1 dropped", 32'(msi_irq[1]), 32'h0);
        idle("R7");
        check(msi_irq[1] === 1'b1, "R7 group1 re-asserted", 32'(msi_irq[1]), 32'h1);

        // R8/R9 INTx line 2
        intx_level = 4'b0100;
        cyc(1'b1, 12'h1A8, 32'h1, 1'b0, 5'd0, "R8");
        rd_chk(12'h1A4, "R8 intx status");
        rd_chk(12'h1A8, "R8 intx enable");
        idle("R8");
        check(intx_irq[2] === 1'b1, "R8 intx2 asserted", 32'(intx_irq), 32'h4);
        cyc(1'b1, 12'h050, 32'd2, 1'b0, 5'd0, "R9");
        check(intx_irq[2] === 1'b0, "R9 intx2 dropped", 32'(intx_irq[2]), 32'h0);
        idle("R9");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int k = int'($urandom_range(0, 7));
            int g = int'($urandom_range(0, 7));
            logic [31:0] r = $urandom;
            case (k)
                0: cyc(1'b1, 12'h054, r, 1'b0, 5'd0, "R1 rnd");
                1: cyc(1'b0, 12'h000, 32'h0, 1'b1, r[4:0], "R1 rnd");
                2: cyc(1'b1, 12'h104 + 12'(16 * g), r, 1'b1, r[9:5], "R4 rnd");
                3: cyc(1'b1, 12'h104 + 12'(16 * g), r, 1'b0, 5'd0, "R3 rnd");
                4: cyc(1'b1, 12'h108 + 12'(16 * g), r, 1'b0, 5'd0, "R5 rnd");
                5: cyc(1'b1, 12'h10C + 12'(16 * g), r, 1'b0, 5'd0, "R5 rnd");
                6: cyc(1'b1, 12'h050, 32'(r % 12), 1'b0, 5'd0, "R7 R9 rnd");
                default: begin
                    intx_level = r[3:0];
                    cyc(1'b1, 12'h188 + 12'(16 * (g % 4)) + (r[4] ? 12'h4 : 12'h0),
                        {31'h0, r[5]}, 1'b0, 5'd0, "R8 rnd");
                end
            endcase
            rd_chk(12'h100 + 12'(16 * int'($urandom_range(0, 11))) +
                   12'(4 * int'($urandom_range(1, 3))), "R3 R5 R8 readback");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule